// File: doc/BRIEF.md
# Flash Multi-Block Erase Command Sequencer

This block is the device-side command front end of a parallel NOR flash, restricted to the erase-by-block instruction. Bus write cycles arrive as an address/data stream, one item per write-enable rising edge. The block recognises the two unlock pairs around the erase setup command, and then takes confirm writes whose upper address bits name a block to erase. Each accepted confirm adds its block to a selection bitmap and restarts an acceptance window. When the window runs out with no new confirm, the selected blocks are handed to an erase engine.

The erase engine is a counter model of the cell array. For each selected block, lowest index first, it writes 00h to every byte and then FFh to every byte, as a stream of cell writes. While erasing, the sequencer accepts only a suspend command, a resume (a confirm written while suspended) and the read/reset command. Every other write is dropped. A wrong byte anywhere in the command sequence returns the block to read-array mode with an empty selection.

The write input is valid/ready. `wr_ready` is low only during reset and high after it, so a write is taken on every cycle in which `wr_valid` is high. The cell write output is valid/ready with full back-pressure. While `cell_ready` is low, `cell_valid`, `cell_blk`, `cell_off` and `cell_data` hold, and the engine does not advance.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset `in_read` is 1, `blk_map` is 0, `cell_valid` is 0, at most one of `in_read`, `tmo_run`, `erase_busy`, `suspended` is high at any time, and `wr_ready` is 1 once reset is released.
- R2: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 30h@any opens the acceptance window (`tmo_run`=1). Only address bits [10:0] are compared for the fixed addresses. The confirm's top log2(NUM_BLK) address bits select the block, whose bit in `blk_map` is set.
- R3: Any write that does not match the expected step, including a non-30h byte in place of the first confirm, returns to `in_read`=1 with `blk_map`=0.
- R4: After the last accepted confirm, `tmo_run` stays high for exactly TMO_CYC cycles. `erase_busy` then rises in the next cycle.
- R5: A 30h write during the window adds its block to `blk_map` and restarts the full window, even when it arrives in the window's final cycle. The map only grows during the window.
- R6: Any non-30h write during the window aborts to read-array mode with `blk_map`=0, and no cell write follows.
- R7: The engine emits, for each selected block in ascending index order, BLK_BYTES writes of 00h at offsets 0 to BLK_BYTES-1, then BLK_BYTES writes of FFh at the same offsets. After the final write it returns to `in_read`=1 and pulses `erase_done` for one cycle. The cell outputs hold while `cell_ready` is low.
- R8: During the erase, writes other than B0h and F0h have no effect on the cell write stream.
- R9: B0h during the erase sets `suspended` and stops cell writes, and other writes are ignored while suspended. 30h resumes the erase from the exact point where it stopped.
- R10: F0h at any address, written during an erase, a suspension or a command step, returns to read-array mode with `blk_map`=0 and no further cell writes or `erase_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write present (one write-enable rising edge) |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data |
| cell_valid | output | 1 | Cell write available |
| cell_ready | input | 1 | Cell array takes the write |
| cell_blk | output | log2(NUM_BLK) | Block of the cell write |
| cell_off | output | log2(BLK_BYTES) | Byte offset within the block |
| cell_data | output | 8 | 00h while presetting, FFh while erasing |
| blk_map | output | NUM_BLK | Blocks selected or still pending |
| in_read | output | 1 | Read-array mode |
| tmo_run | output | 1 | Acceptance window running |
| erase_busy | output | 1 | Erase in progress |
| suspended | output | 1 | Erase suspended |
| erase_done | output | 1 | One-cycle pulse when an erase completes |

## Verification
The two functions that can meet in one cycle are the expiry of the acceptance window and the arrival of a further confirm. The bench times a confirm so that it is accepted on the very edge at which the window would close. It then judges the outcome at the ports: `tmo_run` must still be high, `erase_busy` low, both blocks present in `blk_map`, and a fresh window of full length must follow. A second meeting point, a suspend or reset write landing while a cell write is stalled by back-pressure, is reached through random `cell_ready` gaps. It is judged by comparing the whole cell write stream against the expected sequence.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int CMP_W = 11;
  localparam logic [CMP_W-1:0] ADR_KEY_A = 11'h555;
  localparam logic [CMP_W-1:0] ADR_KEY_B = 11'h2AA;
  localparam logic [7:0] BYTE_KEY_A = 8'hAA;
  localparam logic [7:0] BYTE_KEY_B = 8'h55;
  localparam logic [7:0] BYTE_SETUP = 8'h80;
  localparam logic [7:0] BYTE_CONF  = 8'h30;
  localparam logic [7:0] BYTE_SUSP  = 8'hB0;
  localparam logic [7:0] BYTE_RESET = 8'hF0;
  localparam logic [7:0] FILL_PRE   = 8'h00;
  localparam logic [7:0] FILL_ERA   = 8'hFF;

  typedef enum logic [3:0] {
    SQ_READ, SQ_KEY1, SQ_KEY2, SQ_SETUP, SQ_SKEY1, SQ_SKEY2,
    SQ_WIN, SQ_ERASE, SQ_SUSP
  } seq_st_t;
endpackage

// File: rtl/fes_prio_enc.sv
module fes_prio_enc #(
  parameter int N = 8,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fes_timeout.sv
module fes_timeout #(
  parameter int TMO_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(TMO_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= CW'(TMO_CYC - 1);
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/fes_erase_engine.sv
module fes_erase_engine
  import flash_erase_pkg::*;
#(
  parameter int NUM_BLK   = 8,
  parameter int BLK_BYTES = 4,
  parameter int BLK_W     = $clog2(NUM_BLK),
  parameter int OFF_W     = $clog2(BLK_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               flush,
  input  logic [NUM_BLK-1:0] pend,
  input  logic               cell_ready,
  output logic               cell_valid,
  output logic [BLK_W-1:0]   cell_blk,
  output logic [OFF_W-1:0]   cell_off,
  output logic [7:0]         cell_data,
  output logic               blk_fin,
  output logic [BLK_W-1:0]   fin_idx
);
  logic             phase;
  logic [OFF_W-1:0] off;
  logic [BLK_W-1:0] cur;
  logic             any;
  logic             hs;
  logic             last_off;

  fes_prio_enc #(.N(NUM_BLK), .W(BLK_W)) u_pick (
    .req (pend),
    .idx (cur),
    .any (any)
  );

  assign cell_valid = run && any;
  assign cell_blk   = cur;
  assign cell_off   = off;
  assign cell_data  = phase ? FILL_ERA : FILL_PRE;
  assign hs         = cell_valid && cell_ready;
  assign last_off   = (off == OFF_W'(BLK_BYTES - 1));
  assign blk_fin    = hs && phase && last_off;
  assign fin_idx    = cur;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      off   <= '0;
      phase <= 1'b0;
    end else if (hs) begin
      if (last_off) begin
        off   <= '0;
        phase <= ~phase;
      end else begin
        off <= off + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int NUM_BLK   = 8,
  parameter int BLK_BYTES = 4,
  parameter int TMO_CYC   = 16,
  localparam int BLK_W    = $clog2(NUM_BLK),
  localparam int OFF_W    = $clog2(BLK_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  output logic               cell_valid,
  input  logic               cell_ready,
  output logic [BLK_W-1:0]   cell_blk,
  output logic [OFF_W-1:0]   cell_off,
  output logic [7:0]         cell_data,
  output logic [NUM_BLK-1:0] blk_map,
  output logic               in_read,
  output logic               tmo_run,
  output logic               erase_busy,
  output logic               suspended,
  output logic               erase_done
);
  seq_st_t st, nxt;
  logic rdy_q;
  logic acc;
  logic [CMP_W-1:0] lo;
  logic [BLK_W-1:0] sel_blk;
  logic key_a, key_b, is_setup, is_conf, is_susp, is_reset;
  logic ld, set_bit, flush, done_nxt;
  logic tmo_exp;
  logic blk_fin;
  logic [BLK_W-1:0] fin_idx;
  logic [NUM_BLK-1:0] fin_mask;
  logic last_fin;
  logic unused_addr;

  assign acc      = wr_valid && rdy_q;
  assign lo       = wr_addr[CMP_W-1:0];
  assign sel_blk  = wr_addr[ADDR_W-1 -: BLK_W];
  assign key_a    = (wr_data == BYTE_KEY_A) && (lo == ADR_KEY_A);
  assign key_b    = (wr_data == BYTE_KEY_B) && (lo == ADR_KEY_B);
  assign is_setup = (wr_data == BYTE_SETUP) && (lo == ADR_KEY_A);
  assign is_conf  = (wr_data == BYTE_CONF);
  assign is_susp  = (wr_data == BYTE_SUSP);
  assign is_reset = (wr_data == BYTE_RESET);
  assign unused_addr = ^wr_addr;

  generate
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_mask
      assign fin_mask[g] = (fin_idx == BLK_W'(g));
    end
  endgenerate

  assign last_fin = blk_fin && ((blk_map & ~fin_mask) == '0);

  fes_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ld),
    .run    (st == SQ_WIN),
    .expire (tmo_exp)
  );

  fes_erase_engine #(
    .NUM_BLK   (NUM_BLK),
    .BLK_BYTES (BLK_BYTES),
    .BLK_W     (BLK_W),
    .OFF_W     (OFF_W)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (st == SQ_ERASE),
    .flush      (flush),
    .pend       (blk_map),
    .cell_ready (cell_ready),
    .cell_valid (cell_valid),
    .cell_blk   (cell_blk),
    .cell_off   (cell_off),
    .cell_data  (cell_data),
    .blk_fin    (blk_fin),
    .fin_idx    (fin_idx)
  );

  always_comb begin
    nxt      = st;
    ld       = 1'b0;
    set_bit  = 1'b0;
    flush    = 1'b0;
    done_nxt = 1'b0;
    unique case (st)
      SQ_READ:  if (acc && key_a) nxt = SQ_KEY1;
      SQ_KEY1:  if (acc) nxt = key_b ? SQ_KEY2 : SQ_READ;
      SQ_KEY2:  if (acc) nxt = is_setup ? SQ_SETUP : SQ_READ;
      SQ_SETUP: if (acc) nxt = key_a ? SQ_SKEY1 : SQ_READ;
      SQ_SKEY1: if (acc) nxt = key_b ? SQ_SKEY2 : SQ_READ;
      SQ_SKEY2: begin
        if (acc) begin
          if (is_conf) begin
            nxt     = SQ_WIN;
            ld      = 1'b1;
            set_bit = 1'b1;
          end else begin
            nxt = SQ_READ;
          end
        end
      end
      SQ_WIN: begin
        if (acc) begin
          if (is_conf) begin
            ld      = 1'b1;
            set_bit = 1'b1;
          end else begin
            nxt = SQ_READ;
          end
        end else if (tmo_exp) begin
          nxt = SQ_ERASE;
        end
      end
      SQ_ERASE: begin
        if (acc && is_reset) begin
          nxt   = SQ_READ;
          flush = 1'b1;
        end else if (last_fin) begin
          nxt      = SQ_READ;
          done_nxt = 1'b1;
        end else if (acc && is_susp) begin
          nxt = SQ_SUSP;
        end
      end
      SQ_SUSP: begin
        if (acc && is_reset) begin
          nxt   = SQ_READ;
          flush = 1'b1;
        end else if (acc && is_conf) begin
          nxt = SQ_ERASE;
        end
      end
      default: nxt = SQ_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SQ_READ;
      rdy_q      <= 1'b0;
      erase_done <= 1'b0;
      blk_map    <= '0;
    end else begin
      st         <= nxt;
      rdy_q      <= 1'b1;
      erase_done <= done_nxt;
      if (nxt == SQ_READ) begin
        blk_map <= '0;
      end else begin
        if (set_bit) blk_map[sel_blk] <= 1'b1;
        if (blk_fin) blk_map[fin_idx] <= 1'b0;
      end
    end
  end

  assign wr_ready   = rdy_q;
  assign in_read    = (st == SQ_READ);
  assign tmo_run    = (st == SQ_WIN);
  assign erase_busy = (st == SQ_ERASE);
  assign suspended  = (st == SQ_SUSP);
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3,
  parameter int OFF_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic               cell_valid,
  input logic               cell_ready,
  input logic [BLK_W-1:0]   cell_blk,
  input logic [OFF_W-1:0]   cell_off,
  input logic [7:0]         cell_data,
  input logic [NUM_BLK-1:0] blk_map,
  input logic               in_read,
  input logic               tmo_run,
  input logic               erase_busy,
  input logic               suspended,
  input logic               erase_done
);
  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_read, tmo_run, erase_busy, suspended})); // R1

  AST_READ_MAP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    in_read |-> (blk_map == '0)); // R3

  AST_ERASE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_busy) |-> $past(tmo_run) || $past(suspended)); // R4

  AST_WINDOW_MAP_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_run && $past(tmo_run) |-> ((blk_map & $past(blk_map)) == $past(blk_map))); // R5

  AST_WINDOW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_run) |-> (erase_busy || in_read)); // R6

  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && !cell_ready && !wr_valid |=>
      cell_valid && $stable(cell_blk) && $stable(cell_off) && $stable(cell_data)); // R7

  AST_DONE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |-> in_read && $past(erase_busy)); // R7

  AST_CELL_ONLY_ERASING: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> erase_busy && (blk_map != '0)); // R8

  AST_SUSPEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !cell_valid); // R9
endmodule

bind flash_erase_seq fes_checker #(
  .NUM_BLK (NUM_BLK),
  .BLK_W   (BLK_W),
  .OFF_W   (OFF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .cell_valid (cell_valid),
  .cell_ready (cell_ready),
  .cell_blk   (cell_blk),
  .cell_off   (cell_off),
  .cell_data  (cell_data),
  .blk_map    (blk_map),
  .in_read    (in_read),
  .tmo_run    (tmo_run),
  .erase_busy (erase_busy),
  .suspended  (suspended),
  .erase_done (erase_done)
);

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
  localparam int ADDR_W    = 18;
  localparam int NUM_BLK   = 8;
  localparam int BLK_BYTES = 4;
  localparam int TMO_CYC   = 16;
  localparam int BLK_W     = $clog2(NUM_BLK);
  localparam int OFF_W     = $clog2(BLK_BYTES);
  localparam int EW        = BLK_W + OFF_W + 8;
  localparam int REC_MAX   = 4096;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               wr_valid = 1'b0;
  logic               wr_ready;
  logic [ADDR_W-1:0]  wr_addr = '0;
  logic [7:0]         wr_data = '0;
  logic               cell_valid;
  logic               cell_ready = 1'b1;
  logic [BLK_W-1:0]   cell_blk;
  logic [OFF_W-1:0]   cell_off;
  logic [7:0]         cell_data;
  logic [NUM_BLK-1:0] blk_map;
  logic               in_read, tmo_run, erase_busy, suspended, erase_done;

  flash_erase_seq #(
    .ADDR_W (ADDR_W), .NUM_BLK (NUM_BLK), .BLK_BYTES (BLK_BYTES), .TMO_CYC (TMO_CYC)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid), .wr_ready (wr_ready),
    .wr_addr (wr_addr), .wr_data (wr_data), .cell_valid (cell_valid),
    .cell_ready (cell_ready), .cell_blk (cell_blk), .cell_off (cell_off),
    .cell_data (cell_data), .blk_map (blk_map), .in_read (in_read),
    .tmo_run (tmo_run), .erase_busy (erase_busy), .suspended (suspended),
    .erase_done (erase_done)
  );

  int checks = 0;
  int errors = 0;
  bit bp_en = 1'b0;

  logic [EW-1:0] rec [0:REC_MAX-1];
  int rec_n  = 0;
  int done_n = 0;

  always @(negedge clk) cell_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;

  always @(negedge clk) begin
    #2;
    if (rst_n && cell_valid && cell_ready && rec_n < REC_MAX) begin
      rec[rec_n] = {cell_blk, cell_off, cell_data};
      rec_n++;
    end
    if (rst_n && erase_done) done_n++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] fixed_adr(input logic [10:0] a);
    return ADDR_W'({$urandom} << 11) | ADDR_W'(a);
  endfunction

  function automatic logic [ADDR_W-1:0] blk_adr(input int b);
    return ADDR_W'(b << (ADDR_W - BLK_W)) | ADDR_W'($urandom % (1 << (ADDR_W - BLK_W)));
  endfunction

  function automatic logic [EW-1:0] exp_ent(input logic [NUM_BLK-1:0] m, input int k);
    int per = 2 * BLK_BYTES;
    int n = k / per;
    int j = k % per;
    int seen = 0;
    int b = 0;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (m[i]) begin
        if (seen == n) b = i;
        seen++;
      end
    end
    return {BLK_W'(b), OFF_W'(j % BLK_BYTES), (j < BLK_BYTES) ? 8'h00 : 8'hFF};
  endfunction

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prefix();
    wr(fixed_adr(11'h555), 8'hAA);
    wr(fixed_adr(11'h2AA), 8'h55);
    wr(fixed_adr(11'h555), 8'h80);
    wr(fixed_adr(11'h555), 8'hAA);
    wr(fixed_adr(11'h2AA), 8'h55);
  endtask

  task automatic confirm(input int b);
    wr(blk_adr(b), 8'h30);
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 200 && !erase_busy; i++) @(negedge clk);
  endtask

  task automatic wait_read();
    for (int i = 0; i < 5000 && !in_read; i++) @(negedge clk);
    idle(1);
  endtask

  task automatic check_stream(input logic [NUM_BLK-1:0] m, input int base, input string req);
    int cnt = rec_n - base;
    int want = 2 * BLK_BYTES * $countones(m);
    int bad = -1;
    chk(cnt == want, req, cnt, want);
    for (int k = 0; k < cnt && k < want; k++)
      if (bad < 0 && rec[base + k] != exp_ent(m, k)) bad = k;
    if (bad >= 0) chk(1'b0, req, rec[base + bad], exp_ent(m, bad));
    else chk(1'b1, req, 0, 0);
  endtask

  task automatic count_window(input string req);
    int w = 0;
    while (tmo_run && w < 1000) begin
      w++;
      @(negedge clk);
    end
    chk(w == TMO_CYC, req, w, TMO_CYC);
    chk(erase_busy, req, erase_busy, 1);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    int dbase;
    int n0;
    logic [NUM_BLK-1:0] m;
    void'($urandom(32'd2024));
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(in_read && blk_map == '0 && !cell_valid, "R1", {in_read, blk_map, cell_valid}, {1'b1, 8'h00, 1'b0});
    chk(wr_ready, "R1", wr_ready, 1);

    // R2 + R4 + R7 single block
    base = rec_n; dbase = done_n;
    prefix();
    confirm(5);
    chk(tmo_run && blk_map == 8'h20, "R2", {tmo_run, blk_map}, {1'b1, 8'h20});
    count_window("R4");
    wait_read();
    check_stream(8'h20, base, "R7");
    chk(done_n - dbase == 1, "R7", done_n - dbase, 1);
    chk(in_read && blk_map == '0, "R7", blk_map, 0);

    // R5 confirm landing on the window's final cycle
    base = rec_n;
    prefix();
    confirm(6);
    idle(TMO_CYC - 2);
    confirm(1);
    chk(tmo_run && !erase_busy, "R5", {tmo_run, erase_busy}, 2'b10);
    chk(blk_map == 8'h42, "R5", blk_map, 8'h42);
    count_window("R5");
    wait_read();
    check_stream(8'h42, base, "R7");

    // R3 aborts
    wr(fixed_adr(11'h555), 8'hAA);
    wr(fixed_adr(11'h123), 8'h55);
    chk(in_read, "R3", in_read, 1);
    wr(fixed_adr(11'h555), 8'hAA);
    wr(fixed_adr(11'h2AA), 8'h55);
    wr(fixed_adr(11'h555), 8'h90);
    chk(in_read, "R3", in_read, 1);
    base = rec_n;
    prefix();
    wr(blk_adr(4), 8'h10);
    chk(in_read && blk_map == '0, "R3", blk_map, 0);
    idle(TMO_CYC + 4);
    chk(rec_n == base, "R3", rec_n - base, 0);

    // R10 reset during setup steps
    wr(fixed_adr(11'h555), 8'hAA);
    wr(fixed_adr(11'h2AA), 8'h55);
    wr(fixed_adr(11'h555), 8'h80);
    wr(fixed_adr(11'h7FF), 8'hF0);
    chk(in_read, "R10", in_read, 1);

    // R6 window abort
    base = rec_n;
    prefix();
    confirm(2);
    wr(blk_adr(3), 8'h55);
    chk(in_read && blk_map == '0, "R6", blk_map, 0);
    idle(40);
    chk(rec_n == base, "R6", rec_n - base, 0);

    // R8 ignored writes during erase, with back-pressure
    bp_en = 1'b1;
    base = rec_n;
    prefix();
    confirm(7);
    confirm(0);
    wait_busy();
    wr(fixed_adr(11'h555), 8'hAA);
    wr(fixed_adr(11'h2AA), 8'h55);
    wr(blk_adr(3), 8'h30);
    wr(fixed_adr(11'h555), 8'h80);
    wait_read();
    check_stream(8'h81, base, "R8");
    bp_en = 1'b0;

    // R9 suspend and resume
    base = rec_n;
    prefix();
    confirm(3);
    confirm(4);
    wait_busy();
    idle(3);
    wr(blk_adr(0), 8'hB0);
    chk(suspended && !cell_valid, "R9", {suspended, cell_valid}, 2'b10);
    n0 = rec_n;
    idle(20);
    wr(fixed_adr(11'h555), 8'hAA);
    wr(blk_adr(2), 8'h80);
    chk(rec_n == n0 && suspended, "R9", rec_n - n0, 0);
    wr(blk_adr(5), 8'h30);
    chk(erase_busy, "R9", erase_busy, 1);
    wait_read();
    check_stream(8'h18, base, "R9");

    // R10 reset during erase and during suspension
    dbase = done_n;
    prefix();
    confirm(6);
    wait_busy();
    idle(2);
    wr(blk_adr(1), 8'hF0);
    chk(in_read && blk_map == '0 && !cell_valid, "R10", {in_read, blk_map}, {1'b1, 8'h00});
    n0 = rec_n;
    idle(30);
    chk(done_n == dbase && rec_n == n0, "R10", done_n - dbase, 0);
    prefix();
    confirm(2);
    wait_busy();
    wr(blk_adr(0), 8'hB0);
    wr(blk_adr(0), 8'hF0);
    chk(in_read && blk_map == '0, "R10", blk_map, 0);

    // random multi-block erases
    for (int it = 0; it < 25; it++) begin
      int nb;
      bp_en = ($urandom % 2) == 1;
      nb = 1 + ($urandom % 3);
      m = '0;
      base = rec_n; dbase = done_n;
      prefix();
      for (int j = 0; j < nb; j++) begin
        int b = $urandom % NUM_BLK;
        confirm(b);
        m[b] = 1'b1;
        idle($urandom % (TMO_CYC - 3));
      end
      chk(blk_map == m || erase_busy, "R5", blk_map, m);
      wait_busy();
      for (int j = 0; j < int'($urandom % 3); j++) begin
        logic [7:0] d = 8'($urandom);
        if (d == 8'hB0 || d == 8'hF0) d = 8'h00;
        wr(ADDR_W'($urandom), d);
      end
      wait_read();
      check_stream(m, base, "R7");
      chk(done_n - dbase == 1, "R7", done_n - dbase, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule